// File: doc/BRIEF.md
# Audio Automatic Level Controller

This block sets the 6-bit code for the programmable gain stage in a microphone input path. It watches a stream of signed PCM samples that arrive with a one-cycle valid strobe. When the magnitude of a sample goes above a selectable limit level, the gain code drops by one 0.5 dB step. After a full recovery window of quiet samples, the gain code rises by one step, but never above a programmed ceiling. An optional zero-crossing mode holds each gain change back until the input changes sign. If no sign change comes within the timeout, the change is applied when the timeout expires. One 2-bit period code sets both the recovery window and this timeout.

Software sets up the controller while `enable` is low. While disabled, the configuration inputs are copied into internal registers on every cycle, and a pulse on `gainLoad` preloads the start gain. When `enable` goes high, the copied settings are frozen and regulation starts from the preloaded gain. When `enable` goes low again, the gain code keeps the last value the controller produced.

Top module: `alc_gain_ctrl`

## Requirements
- R1: Each applied change moves `gainCode` by exactly one code (one 0.5 dB step). `gainCode` never changes by more than one code per cycle.
- R2: A valid sample is a limit hit when its magnitude is strictly greater than the threshold. `limitSel` picks the threshold (16-bit samples): 00 = 20675 (-4 dBFS), 01 = 16423, 10 = 13045, 11 = 10362. An input of -32768 is treated as magnitude 32767.
- R3: With `zcEnable` latched at 0, a limit hit lowers `gainCode` by one at the clock edge that takes in the sample. At code 0 the gain stays at 0 and does not wrap.
- R4: After P consecutive valid samples with no limit hit, the gain rises by one, at the edge of the P-th sample. A limit hit restarts the count. The gain never rises above the latched `maxGain`.
- R5: `periodSel` sets P: 00 = 128, 01 = 256, 10 and 11 = 512 valid samples. The same P is used for the recovery window and for the zero-crossing timeout.
- R6: With `zcEnable` latched at 1, a gain change is first held as pending. It is applied on a later valid sample whose sign bit differs from the sign bit of the previous valid sample.
- R7: With `zcEnable` latched at 1, a pending change with no sign change is applied on the P-th valid sample after the sample that requested it.
- R8: `gainLoad` high while `enable` is 0 loads `startGain` into `gainCode` at the next edge. While `enable` is 1, `gainLoad` is ignored.
- R9: While `enable` is 1, changes on `limitSel`, `periodSel`, `maxGain` and `zcEnable` have no effect. The values in use are the ones present in the last cycle before `enable` went high.
- R10: While `enable` is 0, `gainCode` holds its last value, except when a load is done as in R8.
- R11: After reset `gainCode` is 0.
- R12: Cycles with `sampleValid` low do not change `gainCode`, any counter or any pending state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sampleValid | input | 1 | Marks a new sample on `sampleIn` |
| sampleIn | input | SAMPLE_W | Signed PCM sample |
| enable | input | 1 | Runs the controller; high freezes the configuration |
| gainLoad | input | 1 | Loads the start gain while disabled |
| startGain | input | GAIN_W | Start gain value |
| maxGain | input | GAIN_W | Recovery ceiling |
| limitSel | input | 2 | Threshold select |
| periodSel | input | 2 | Recovery window and timeout select |
| zcEnable | input | 1 | Holds gain changes until a zero crossing |
| gainCode | output | GAIN_W | Gain code for the analog stage |

## Verification
The gain code is the only output. Any fault inside the block must therefore show up as a wrong step, or as a step in the wrong cycle. A recovery counter that is off by one moves the rising step one sample early or late. The checks therefore sample the gain one sample before each window or timeout ends, and again right at its end. Errors in the config latch or the zero-crossing memory do not show at once. They appear only on the first limit hit or sign change after the fault, so each such check comes right after a sample that depends on that state.

// File: rtl/alc_pkg.sv
package alc_pkg;

  typedef struct packed {
    logic gainDown;
    logic gainUp;
  } gainStrobe_t;

  // limit threshold scaled to a signed full scale of 2^(sw-1)
  function automatic logic [63:0] limitThreshold(input logic [1:0] sel, input int sw);
    logic [63:0] frac;
    case (sel)
      2'b00:   frac = 64'd20675;
      2'b01:   frac = 64'd16423;
      2'b10:   frac = 64'd13045;
      default: frac = 64'd10362;
    endcase
    return (frac << (sw - 1)) >> 15;
  endfunction

endpackage

// File: rtl/alc_datapath.sv
module alc_datapath
  import alc_pkg::*;
#(
  parameter int SAMPLE_W = 16,
  parameter int GAIN_W   = 6
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       sampleValid,
  input  logic signed [SAMPLE_W-1:0] sampleIn,
  input  logic                       enable,
  input  logic                       gainLoad,
  input  logic [GAIN_W-1:0]          startGain,
  input  logic [GAIN_W-1:0]          maxGain,
  input  logic [1:0]                 limitSel,
  input  logic [1:0]                 periodSel,
  input  logic                       zcEnable,
  input  gainStrobe_t                strobe,
  output logic                       limitHit,
  output logic                       zeroCross,
  output logic [1:0]                 cfgPeriod,
  output logic                       cfgZc,
  output logic [GAIN_W-1:0]          cfgMax,
  output logic [GAIN_W-1:0]          gainCode
);

  localparam logic [SAMPLE_W-1:0] MOST_NEG = {1'b1, {(SAMPLE_W-1){1'b0}}};
  localparam logic [SAMPLE_W-1:0] MOST_POS = {1'b0, {(SAMPLE_W-1){1'b1}}};

  logic [1:0]          cfgLimit;
  logic                prevSign;
  logic [SAMPLE_W-1:0] magVal;
  logic [SAMPLE_W-1:0] thrVal;
  logic [63:0]         thrWide;
  logic [GAIN_W-1:0]   gainQ;

  // configuration tracks the inputs while idle, frozen while running
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfgLimit  <= '0;
      cfgPeriod <= '0;
      cfgZc     <= 1'b0;
      cfgMax    <= '0;
    end else if (!enable) begin
      cfgLimit  <= limitSel;
      cfgPeriod <= periodSel;
      cfgZc     <= zcEnable;
      cfgMax    <= maxGain;
    end
  end

  always_comb begin
    if (!sampleIn[SAMPLE_W-1])
      magVal = sampleIn;
    else if (sampleIn == MOST_NEG)
      magVal = MOST_POS;
    else
      magVal = ~sampleIn + 1'b1;
  end

  assign thrWide   = limitThreshold(cfgLimit, SAMPLE_W);
  assign thrVal    = thrWide[SAMPLE_W-1:0];
  assign limitHit  = sampleValid && (magVal > thrVal);
  assign zeroCross = sampleValid && (sampleIn[SAMPLE_W-1] != prevSign);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      prevSign <= 1'b0;
    else if (sampleValid)
      prevSign <= sampleIn[SAMPLE_W-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      gainQ <= '0;
    else if (!enable) begin
      if (gainLoad)
        gainQ <= startGain;
    end else if (strobe.gainDown) begin
      if (gainQ != '0)
        gainQ <= gainQ - 1'b1;
    end else if (strobe.gainUp) begin
      if (gainQ < cfgMax)
        gainQ <= gainQ + 1'b1;
    end
  end

  assign gainCode = gainQ;

endmodule

// File: rtl/alc_control.sv
module alc_control
  import alc_pkg::*;
#(
  parameter int BASE_PERIOD = 128
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        enable,
  input  logic        sampleValid,
  input  logic        limitHit,
  input  logic        zeroCross,
  input  logic [1:0]  cfgPeriod,
  input  logic        cfgZc,
  output gainStrobe_t strobe
);

  localparam int CNT_W = $clog2(BASE_PERIOD * 4);

  typedef enum logic [1:0] {PEND_NONE, PEND_DOWN, PEND_UP} pend_e;

  pend_e            pendQ, pendD;
  logic [CNT_W-1:0] quietQ, quietD;
  logic [CNT_W-1:0] toQ, toD;
  logic [CNT_W-1:0] lastIdx;
  logic             windowDone;
  logic             applyNow;
  logic             step;

  // codes 10 and 11 both select four base periods
  always_comb begin
    case (cfgPeriod)
      2'b00:   lastIdx = CNT_W'(BASE_PERIOD - 1);
      2'b01:   lastIdx = CNT_W'(BASE_PERIOD * 2 - 1);
      default: lastIdx = CNT_W'(BASE_PERIOD * 4 - 1);
    endcase
  end

  assign step       = enable && sampleValid;
  assign windowDone = !limitHit && (quietQ == lastIdx);
  assign applyNow   = (pendQ != PEND_NONE) && (zeroCross || (toQ == lastIdx));

  always_comb begin
    strobe = '0;
    pendD  = pendQ;
    toD    = toQ;
    quietD = quietQ;
    if (!enable) begin
      pendD  = PEND_NONE;
      toD    = '0;
      quietD = '0;
    end else if (step) begin
      quietD = (limitHit || windowDone) ? '0 : quietQ + 1'b1;
      if (!cfgZc) begin
        strobe.gainDown = limitHit;
        strobe.gainUp   = windowDone;
        pendD           = PEND_NONE;
        toD             = '0;
      end else begin
        if (applyNow) begin
          strobe.gainDown = (pendQ == PEND_DOWN);
          strobe.gainUp   = (pendQ == PEND_UP);
        end
        if (limitHit) begin
          if (pendQ == PEND_DOWN && !applyNow) begin
            toD = toQ + 1'b1;
          end else begin
            pendD = PEND_DOWN;
            toD   = '0;
          end
        end else if (windowDone && (pendQ == PEND_NONE || applyNow)) begin
          pendD = PEND_UP;
          toD   = '0;
        end else if (applyNow) begin
          pendD = PEND_NONE;
          toD   = '0;
        end else if (pendQ != PEND_NONE) begin
          toD = toQ + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pendQ  <= PEND_NONE;
      toQ    <= '0;
      quietQ <= '0;
    end else begin
      pendQ  <= pendD;
      toQ    <= toD;
      quietQ <= quietD;
    end
  end

endmodule

// File: rtl/alc_gain_ctrl.sv
module alc_gain_ctrl
  import alc_pkg::*;
#(
  parameter int SAMPLE_W    = 16,
  parameter int GAIN_W      = 6,
  parameter int BASE_PERIOD = 128
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       sampleValid,
  input  logic signed [SAMPLE_W-1:0] sampleIn,
  input  logic                       enable,
  input  logic                       gainLoad,
  input  logic [GAIN_W-1:0]          startGain,
  input  logic [GAIN_W-1:0]          maxGain,
  input  logic [1:0]                 limitSel,
  input  logic [1:0]                 periodSel,
  input  logic                       zcEnable,
  output logic [GAIN_W-1:0]          gainCode
);

  gainStrobe_t       strobe;
  logic              limitHit;
  logic              zeroCross;
  logic [1:0]        cfgPeriod;
  logic              cfgZc;
  logic [GAIN_W-1:0] cfgMax;

  alc_datapath #(.SAMPLE_W(SAMPLE_W), .GAIN_W(GAIN_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .sampleValid(sampleValid), .sampleIn(sampleIn),
    .enable(enable), .gainLoad(gainLoad), .startGain(startGain), .maxGain(maxGain),
    .limitSel(limitSel), .periodSel(periodSel), .zcEnable(zcEnable), .strobe(strobe),
    .limitHit(limitHit), .zeroCross(zeroCross), .cfgPeriod(cfgPeriod), .cfgZc(cfgZc),
    .cfgMax(cfgMax), .gainCode(gainCode)
  );

  alc_control #(.BASE_PERIOD(BASE_PERIOD)) u_ctl (
    .clk(clk), .rst_n(rst_n), .enable(enable), .sampleValid(sampleValid),
    .limitHit(limitHit), .zeroCross(zeroCross), .cfgPeriod(cfgPeriod), .cfgZc(cfgZc),
    .strobe(strobe)
  );

endmodule

// File: rtl/alc_gain_ctrl_chk.sv
module alc_gain_ctrl_chk #(
  parameter int GAIN_W = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              enable,
  input logic              sampleValid,
  input logic              gainLoad,
  input logic [GAIN_W-1:0] gainCode,
  input logic [GAIN_W-1:0] cfgMax
);

  assert_single_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
    enable |=> (gainCode == $past(gainCode)) || (gainCode == $past(gainCode) + 1'b1)
               || (gainCode + 1'b1 == $past(gainCode)));

  assert_no_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && gainCode == '0) |=> gainCode <= 1);

  assert_ceiling_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && sampleValid && gainCode >= cfgMax) |=> gainCode <= $past(gainCode));

  assert_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!enable && !gainLoad) |=> $stable(gainCode));

  assert_idle_cycle_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && !sampleValid) |=> $stable(gainCode));

endmodule

bind alc_gain_ctrl alc_gain_ctrl_chk #(.GAIN_W(GAIN_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .enable(enable), .sampleValid(sampleValid),
  .gainLoad(gainLoad), .gainCode(gainCode), .cfgMax(cfgMax)
);

// File: tb/alc_gain_ctrl_tb.sv
module alc_gain_ctrl_tb;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               sampleValid = 1'b0;
  logic signed [15:0] sampleIn = '0;
  logic               enable = 1'b0;
  logic               gainLoad = 1'b0;
  logic [5:0]         startGain = '0;
  logic [5:0]         maxGain = '0;
  logic [1:0]         limitSel = '0;
  logic [1:0]         periodSel = '0;
  logic               zcEnable = 1'b0;
  logic [5:0]         gainCode;

  int checkCount = 0;
  int failCount  = 0;
  int cycleCount = 0;

  always #4 clk = ~clk;

  alc_gain_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .sampleValid(sampleValid), .sampleIn(sampleIn),
    .enable(enable), .gainLoad(gainLoad), .startGain(startGain), .maxGain(maxGain),
    .limitSel(limitSel), .periodSel(periodSel), .zcEnable(zcEnable), .gainCode(gainCode)
  );

  typedef struct packed {
    int value;
    int count;
    int expGain;
  } vec_t;

  // immediate mode, P = 128, start 5, ceiling 8, threshold 20675
  localparam vec_t VECS [12] = '{
    '{21000, 1, 4}, '{30000, 2, 2}, '{-32768, 1, 1}, '{20675, 1, 1},
    '{100, 126, 1}, '{100, 1, 2}, '{100, 127, 2}, '{-20676, 1, 1},
    '{0, 128, 2}, '{0, 768, 8}, '{0, 128, 8}, '{30000, 10, 0}
  };

  task automatic check(input string req, input int act, input int expv);
    checkCount++;
    if (act != expv) begin
      failCount++;
      $display("FAIL %s: gainCode=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic push(input int v, input int n);
    for (int i = 0; i < n; i++) begin
      sampleIn    = 16'(v);
      sampleValid = 1'b1;
      @(negedge clk);
    end
    sampleValid = 1'b0;
  endtask

  task automatic setup(input int lim, input int per, input int mx, input int zc, input int start);
    enable    = 1'b0;
    limitSel  = 2'(lim);
    periodSel = 2'(per);
    maxGain   = 6'(mx);
    zcEnable  = 1'(zc);
    startGain = 6'(start);
    gainLoad  = 1'b1;
    @(negedge clk);
    gainLoad  = 1'b0;
    @(negedge clk);
    enable    = 1'b1;
  endtask

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", checkCount, failCount);
    $finish;
  endtask

  always @(posedge clk) begin
    cycleCount <= cycleCount + 1;
    if (cycleCount > 100000) begin
      checkCount++;
      failCount++;
      $display("FAIL watchdog: cycles=%0d expected<=%0d", cycleCount, 100000);
      finishRun();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R11 reset gain", int'(gainCode), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // table walk: R2 R3 R4 in immediate mode
    setup(0, 0, 8, 0, 5);
    for (int k = 0; k < 12; k++) begin
      push(VECS[k].value, VECS[k].count);
      check($sformatf("R3/R4 vector %0d", k), int'(gainCode), VECS[k].expGain);
    end

    // R2 threshold code 11
    setup(3, 0, 8, 0, 5);
    push(10362, 1);
    check("R2 equal to level 11 no hit", int'(gainCode), 5);
    push(10363, 1);
    check("R2 above level 11 hits", int'(gainCode), 4);

    // R9 config lock
    setup(0, 0, 8, 0, 3);
    limitSel = 2'b11; maxGain = 6'd0; zcEnable = 1'b1;
    push(15000, 1);
    check("R9 threshold held", int'(gainCode), 3);
    push(25000, 1);
    check("R9 zero-cross setting held", int'(gainCode), 2);

    // R8 load ignored while running
    startGain = 6'd40; gainLoad = 1'b1;
    @(negedge clk);
    gainLoad = 1'b0;
    check("R8 load ignored when enabled", int'(gainCode), 2);

    // R12 invalid cycles ignored
    sampleIn = 16'sd30000;
    repeat (5) @(negedge clk);
    check("R12 valid low no effect", int'(gainCode), 2);

    // R10 freeze when disabled
    enable = 1'b0;
    push(30000, 5);
    check("R10 gain frozen", int'(gainCode), 2);
    startGain = 6'd9; gainLoad = 1'b1;
    @(negedge clk);
    gainLoad = 1'b0;
    check("R8 load while disabled", int'(gainCode), 9);

    // R5 period 256 and 512
    setup(0, 1, 20, 0, 4);
    push(0, 255);
    check("R5 period 01 not yet", int'(gainCode), 4);
    push(0, 1);
    check("R5 period 01 step", int'(gainCode), 5);
    enable = 1'b0; periodSel = 2'b10;
    @(negedge clk);
    enable = 1'b1;
    push(0, 511);
    check("R5 period 10 not yet", int'(gainCode), 5);
    push(0, 1);
    check("R5 period 10 step", int'(gainCode), 6);

    // R6 R7 zero-cross mode
    enable = 1'b0;
    push(500, 1);
    setup(0, 0, 20, 1, 6);
    push(25000, 1);
    check("R6 change held pending", int'(gainCode), 6);
    push(1000, 3);
    check("R6 no sign change keeps pending", int'(gainCode), 6);
    push(-1000, 1);
    check("R6 applied on sign change", int'(gainCode), 5);
    push(25000, 1);
    check("R7 new request pending", int'(gainCode), 5);
    push(1000, 127);
    check("R7 before timeout", int'(gainCode), 5);
    push(1000, 1);
    check("R7 applied at timeout", int'(gainCode), 4);

    finishRun();
  end

endmodule